// File: doc/BRIEF.md
# BISYNC Character Transmitter with Error Abort

This block turns a stream of characters from a small transmit FIFO into a synchronous serial bit stream, one buffer at a time. A buffer begins when the host raises `buf_start` while clear-to-send is high and the FIFO can supply a first character. Characters then go out back to back, with no gap, until the one tagged as the buffer's last has been sent. A one-cycle `buf_close` pulse then marks the end of the buffer. When no buffer is active, the line rests at its idle level.

Two faults abort a buffer part way through. The first is an underrun: the FIFO cannot supply the next character at a character boundary. The second is clear-to-send falling while a message is in progress. On either fault the block closes the buffer, sets a sticky status flag for that fault, raises the transmit-error interrupt if it is enabled, and halts. It stays halted until a restart command arrives.

Transparent mode adds a rule for escape pairs: an escape character and the byte after it are never split by an underrun. Parity can be switched on, off, or between even and odd while the block is running. The new setting applies from the next character loaded.

Top module: `bsync_tx`

## Requirements
- R1: Each character leaves on `txd` MSB first, one bit per clock. The first bit appears in the cycle after the edge where `fifo_rd` is high. Characters of a buffer follow each other with no gap. Whenever no character is being sent, `txd` is 1.
- R2: With `cfg_par_en`=1, the line carries data bits 6..0 (bit 6 first) followed by a parity bit. Even parity (`cfg_par_odd`=0) makes the parity bit the XOR of bits 6..0; odd parity uses its complement. With `cfg_par_en`=0, all 8 data bits are sent. The setting is sampled as each character is loaded, so it may change during operation.
- R3: A buffer starts only on an edge where `buf_start` and `cts` are both 1 and the FIFO can supply a startable first character. An empty FIFO between buffers is never reported as an error.
- R4: After the final bit of a character tagged `fifo_last`=1, `buf_close` is 1 for exactly one cycle, no status flag is set, and the line returns to idle. A buffer of N characters closes 8·N cycles after its start edge.
- R5: When the FIFO is empty at a character boundary inside a buffer, the block pulses `buf_close`, sets `st_un`, drives idle on the line and halts.
- R6: A transmit error sets `irq` only when `cfg_txe_en`=1. The status flag is set regardless of `cfg_txe_en`.
- R7: While `halted`=1, the block reads nothing from the FIFO, ignores `buf_start` and holds `txd` at 1. A `restart` pulse clears `halted` on the next edge. A `restart` pulse while not halted has no effect.
- R8: With `cfg_transp`=1, a head character equal to 0x10 that is not tagged last is an escape. It is loaded only when `fifo_level`≥2, and the byte after it is sent directly behind it and never starts a new escape. An escape with `fifo_level`=1 delays a buffer's start without error. In the middle of a buffer it causes an underrun, and the escape stays in the FIFO.
- R9: When `cts` is 0 during a message, the next edge aborts the character in flight: `txd` goes to 1, `buf_close` pulses, `st_cts` is set and the block halts.
- R10: Each `clr` bit clears one sticky output on the next edge: bit 0 clears `st_un`, bit 1 clears `st_cts`, bit 2 clears `irq`. A flag being set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cts | input | 1 | Clear-to-send, high permits sending |
| buf_start | input | 1 | Buffer ready to send |
| restart | input | 1 | Restart command, leaves the halted state |
| cfg_par_en | input | 1 | Enable parity bit after 7 data bits |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_transp | input | 1 | Transparent mode with escape pairs |
| cfg_txe_en | input | 1 | Transmit-error interrupt enable |
| clr | input | 3 | Write-one-to-clear: {irq, st_cts, st_un} |
| fifo_level | input | LVL_W | Number of characters in the FIFO |
| fifo_data | input | DATA_W | Head character of the FIFO |
| fifo_last | input | 1 | Head character ends the buffer |
| fifo_rd | output | 1 | Pop strobe for the FIFO head |
| txd | output | 1 | Serial data out |
| buf_close | output | 1 | One-cycle buffer close pulse |
| halted | output | 1 | Channel halted after an error |
| st_un | output | 1 | Sticky underrun status |
| st_cts | output | 1 | Sticky CTS-lost status |
| irq | output | 1 | Sticky transmit-error interrupt |

## Verification
On every cycle, the assertions check the following. The halted state holds until a restart and is left on the edge after one. Nothing is read and the line stays idle while halted. Loads happen only on character boundaries. An underrun flag rises only out of an active buffer. A character after an escape is always available. A CTS drop aborts on the next edge, and the interrupt rises only when enabled. Other properties need the bench's scenarios: the exact bit order and parity of every character, across each parity mode and a mid-buffer mode change; close timing over buffers of different lengths; and the escape rules in each of their placements (at the start of a buffer, in the middle, doubled, and tagged last).

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } tx_state_t;

  localparam int NFLAG   = 2;
  localparam int FLAG_UN = 0;
  localparam int FLAG_CT = 1;
  localparam int CLR_W   = NFLAG + 1;
  localparam int CLR_IRQ = NFLAG;
endpackage

// File: rtl/bsync_fetch.sv
module bsync_fetch #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 5,
  parameter logic [DATA_W-1:0] ESC_CHAR = 8'h10
) (
  input  logic              transp,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              pair_q,
  input  logic [LVL_W-1:0]  level,
  input  logic [DATA_W-1:0] data,
  input  logic              last,
  output logic              fetch_ok,
  output logic              esc_start,
  output logic [DATA_W-1:0] frame
);
  logic has_one, has_two, par_bit;

  assign has_one = (level != '0);
  assign has_two = (level >= LVL_W'(2));

  // an escape opens a pair only if it is not the byte completing a pair
  assign esc_start = transp && !pair_q && !last && (data == ESC_CHAR);
  assign fetch_ok  = has_one && (!esc_start || has_two);

  assign par_bit = (^data[DATA_W-2:0]) ^ par_odd;
  assign frame   = par_en ? {data[DATA_W-2:0], par_bit} : data;
endmodule

// File: rtl/bsync_shift.sv
module bsync_shift #(
  parameter int   DATA_W   = 8,
  parameter logic IDLE_BIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              abort,
  input  logic [DATA_W-1:0] frame,
  output logic              slot_free,
  output logic              txd
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  assign slot_free = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
      txd <= IDLE_BIT;
    end else if (abort) begin
      cnt <= '0;
      txd <= IDLE_BIT;
    end else if (load) begin
      txd <= frame[DATA_W-1];
      sh  <= {frame[DATA_W-2:0], 1'b0};
      cnt <= CNT_W'(DATA_W-1);
    end else if (cnt != '0) begin
      txd <= sh[DATA_W-1];
      sh  <= {sh[DATA_W-2:0], 1'b0};
      cnt <= cnt - 1'b1;
    end else begin
      txd <= IDLE_BIT;
    end
  end

  // R1: a new character only enters on a character boundary
  p_load_on_boundary_r1: assert property (@(posedge clk) disable iff (rst)
    load |-> slot_free);
endmodule

// File: rtl/bsync_flags.sv
module bsync_flags import bsync_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_flag,
  input  logic             irq_en,
  input  logic [CLR_W-1:0] clr,
  output logic [NFLAG-1:0] flag,
  output logic             irq
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flag[g] <= 1'b0;
      else if (set_flag[g]) flag[g] <= 1'b1;
      else if (clr[g])      flag[g] <= 1'b0;
    end

    // R10: a clear without a competing set empties the flag
    p_flag_w1c_r10: assert property (@(posedge clk) disable iff (rst)
      (clr[g] && !set_flag[g]) |=> !flag[g]);
  end

  always_ff @(posedge clk) begin
    if (rst)                          irq <= 1'b0;
    else if ((|set_flag) && irq_en)   irq <= 1'b1;
    else if (clr[CLR_IRQ])            irq <= 1'b0;
  end
endmodule

// File: rtl/bsync_tx.sv
module bsync_tx import bsync_pkg::*; #(
  parameter int   DATA_W = 8,
  parameter int   LVL_W  = 5,
  parameter logic [DATA_W-1:0] ESC_CHAR = 8'h10,
  parameter logic IDLE_BIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cts,
  input  logic              buf_start,
  input  logic              restart,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_transp,
  input  logic              cfg_txe_en,
  input  logic [CLR_W-1:0]  clr,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_last,
  output logic              fifo_rd,
  output logic              txd,
  output logic              buf_close,
  output logic              halted,
  output logic              st_un,
  output logic              st_cts,
  output logic              irq
);
  tx_state_t         state;
  logic              pair_q, last_q;
  logic              fetch_ok, esc_start, slot_free;
  logic [DATA_W-1:0] frame;
  logic              in_run, need, start, load, urun, cts_abort, done;
  logic [NFLAG-1:0]  set_flag, flag;

  bsync_fetch #(.DATA_W(DATA_W), .LVL_W(LVL_W), .ESC_CHAR(ESC_CHAR)) u_fetch (
    .transp(cfg_transp), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .pair_q(pair_q), .level(fifo_level), .data(fifo_data), .last(fifo_last),
    .fetch_ok(fetch_ok), .esc_start(esc_start), .frame(frame)
  );

  assign in_run    = (state == ST_RUN);
  assign need      = in_run && slot_free && !last_q;
  assign cts_abort = in_run && !cts;
  assign done      = in_run && slot_free && last_q && cts;
  assign start     = (state == ST_IDLE) && buf_start && cts && fetch_ok;
  assign load      = start || (need && cts && fetch_ok);
  assign urun      = need && cts && !fetch_ok;
  assign fifo_rd   = load;

  bsync_shift #(.DATA_W(DATA_W), .IDLE_BIT(IDLE_BIT)) u_shift (
    .clk(clk), .rst(rst), .load(load), .abort(cts_abort),
    .frame(frame), .slot_free(slot_free), .txd(txd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pair_q    <= 1'b0;
      last_q    <= 1'b0;
      buf_close <= 1'b0;
    end else begin
      buf_close <= cts_abort || urun || done;
      if (load) begin
        pair_q <= esc_start;
        last_q <= fifo_last;
      end else if (cts_abort || urun || done) begin
        pair_q <= 1'b0;
        last_q <= 1'b0;
      end
      case (state)
        ST_IDLE: if (start) state <= ST_RUN;
        ST_RUN: begin
          if (cts_abort || urun) state <= ST_HALT;
          else if (done)         state <= ST_IDLE;
        end
        ST_HALT: if (restart) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign halted = (state == ST_HALT);

  assign set_flag[FLAG_UN] = urun;
  assign set_flag[FLAG_CT] = cts_abort;

  bsync_flags u_flags (
    .clk(clk), .rst(rst), .set_flag(set_flag), .irq_en(cfg_txe_en),
    .clr(clr), .flag(flag), .irq(irq)
  );

  assign st_un  = flag[FLAG_UN];
  assign st_cts = flag[FLAG_CT];

  // R7: halt is held until a restart, and left on the edge after one
  p_halt_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (halted && !restart) |=> halted);
  p_restart_exits_r7: assert property (@(posedge clk) disable iff (rst)
    (halted && restart) |=> !halted);
  p_no_read_halted_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> !fifo_rd);
  p_idle_line_halted_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (txd == IDLE_BIT));
  // R5: underrun is only ever raised out of an active buffer
  p_un_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(st_un) |-> $past(state == ST_RUN));
  // R8: the byte after an escape is always ready at the boundary
  p_pair_intact_r8: assert property (@(posedge clk) disable iff (rst)
    (pair_q && need && cts) |-> fetch_ok);
  // R6: interrupt only rises with the enable set
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cfg_txe_en));
  // R9: clear-to-send loss aborts on the next edge
  p_cts_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (in_run && !cts) |=> (halted && buf_close && st_cts));
  // R4: close is a single-cycle pulse
  p_close_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    buf_close |=> !buf_close);
endmodule

// File: tb/bsync_tx_test.sv
module bsync_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ESC = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts = 1'b1, buf_start = 1'b0, restart = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, transp = 1'b0, txe_en = 1'b0;
  logic [2:0] clr = 3'b000;
  logic [4:0] fifo_level;
  logic [7:0] fifo_data;
  logic fifo_last, fifo_rd, txd, buf_close, halted, st_un, st_cts, irq;

  logic [8:0] q [0:15];
  logic [4:0] wr_cnt = '0;
  logic [4:0] rd_cnt;
  logic [7:0] exp_sr;
  int left;
  int tb_checks = 0, tb_fails = 0, mon_checks = 0, mon_fails = 0, wd_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_level = wr_cnt - rd_cnt;
  assign fifo_data  = q[rd_cnt[3:0]][7:0];
  assign fifo_last  = q[rd_cnt[3:0]][8];

  bsync_tx uut (
    .clk(clk), .rst(rst), .cts(cts), .buf_start(buf_start), .restart(restart),
    .cfg_par_en(par_en), .cfg_par_odd(par_odd), .cfg_transp(transp),
    .cfg_txe_en(txe_en), .clr(clr), .fifo_level(fifo_level),
    .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_rd(fifo_rd),
    .txd(txd), .buf_close(buf_close), .halted(halted), .st_un(st_un),
    .st_cts(st_cts), .irq(irq)
  );

  function automatic logic [7:0] frame_of(input logic [7:0] d);
    if (!par_en) return d;
    return {d[6:0], (^d[6:0]) ^ par_odd};
  endfunction

  // expected serial stream, built from the requirement formulas
  always @(posedge clk) begin
    if (rst) begin
      left <= 0; rd_cnt <= '0; exp_sr <= '0;
    end else if (fifo_rd) begin
      exp_sr <= frame_of(fifo_data); left <= 8; rd_cnt <= rd_cnt + 1'b1;
    end else if (left != 0) begin
      exp_sr <= {exp_sr[6:0], 1'b0}; left <= left - 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !halted) begin
      mon_checks++;
      if (left != 0 && txd !== exp_sr[7]) begin
        mon_fails++;
        $display("FAIL R1/R2 bit: actual %0b expected %0b", txd, exp_sr[7]);
      end else if (left == 0 && txd !== 1'b1) begin
        mon_fails++;
        $display("FAIL R1 idle line: actual %0b expected 1", txd);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tb_checks++;
    if (act != exp) begin
      tb_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed",
             tb_checks + mon_checks + wd_fail, tb_fails + mon_fails + wd_fail);
  endtask

  task automatic push(input logic [7:0] d, input logic l);
    q[wr_cnt[3:0]] = {l, d};
    wr_cnt = wr_cnt + 1'b1;
  endtask

  task automatic pulse_start();
    buf_start = 1'b1; @(negedge clk); buf_start = 1'b0;
  endtask

  task automatic pulse_restart();
    restart = 1'b1; @(negedge clk); restart = 1'b0;
  endtask

  task automatic pulse_clr(input logic [2:0] v);
    clr = v; @(negedge clk); clr = 3'b000;
  endtask

  task automatic wait_close(output int k);
    k = 0;
    while (!buf_close && k < 200) begin @(negedge clk); k++; end
  endtask

  initial begin
    int k;
    for (int i = 0; i < 16; i++) q[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset txd", txd, 1);
    check("R7 reset halted", halted, 0);
    check("R10 reset flags", {irq, st_cts, st_un}, 0);
    check("R4 reset close", buf_close, 0);

    // R1/R2/R4 sweep over parity modes and data patterns
    txe_en = 1'b1;
    for (int m = 0; m < 3; m++) begin
      par_en = (m != 0); par_odd = (m == 2);
      for (int i = 0; i < 4; i++) begin
        for (int b = 0; b < 3; b++) push(8'(i*37 + b*91 + m*13 + 5), b == 2);
        pulse_start();
        wait_close(k);
        check("R4 close after 24", k, 24);
        check("R4 no flags", {st_cts, st_un}, 0);
        @(negedge clk);
        check("R4 close pulse width", buf_close, 0);
      end
    end

    // R2 parity change in the middle of a buffer
    par_en = 1'b1; par_odd = 1'b0;
    for (int b = 0; b < 3; b++) push(8'(b*29 + 3), b == 2);
    pulse_start();
    repeat (12) @(negedge clk);
    par_odd = 1'b1;
    wait_close(k);
    check("R2 on-the-fly close", k, 12);
    par_en = 1'b0;

    // R3 empty FIFO between buffers is not an error
    pulse_start();
    repeat (12) @(negedge clk);
    check("R3 no underrun when idle", st_un, 0);
    check("R3 not halted when idle", halted, 0);
    push(8'hC3, 1'b1);
    cts = 1'b0;
    pulse_start();
    repeat (4) @(negedge clk);
    check("R3 no start without cts", fifo_level, 1);
    cts = 1'b1;
    pulse_start();
    wait_close(k);
    check("R3 start with cts", k, 8);

    // R5/R6 underrun with interrupt disabled
    @(negedge clk);
    txe_en = 1'b0;
    push(8'h5A, 1'b0); push(8'hA5, 1'b0);
    pulse_start();
    wait_close(k);
    check("R5 underrun boundary", k, 16);
    check("R5 underrun flag", st_un, 1);
    check("R6 irq masked", irq, 0);
    check("R5 halted", halted, 1);
    check("R5 idle line", txd, 1);
    // R7 halted channel ignores a new buffer
    push(8'h7E, 1'b1);
    pulse_start();
    repeat (4) @(negedge clk);
    check("R7 no read while halted", fifo_level, 1);
    check("R7 stays halted", halted, 1);
    pulse_restart();
    check("R7 restart clears halt", halted, 0);
    pulse_clr(3'b001);
    check("R10 clear underrun", st_un, 0);
    pulse_start();
    wait_close(k);
    check("R7 resumes after restart", k, 8);

    // R6/R10 underrun with interrupt enabled, separate clears
    @(negedge clk);
    txe_en = 1'b1;
    push(8'h99, 1'b0);
    pulse_start();
    wait_close(k);
    check("R5 single-char underrun", k, 8);
    check("R6 irq raised", irq, 1);
    @(negedge clk);
    pulse_clr(3'b001);
    check("R10 st_un cleared", st_un, 0);
    check("R10 irq kept", irq, 1);
    pulse_clr(3'b100);
    check("R10 irq cleared", irq, 0);
    pulse_restart();
    pulse_restart();
    check("R7 restart while idle ignored", halted, 0);
    check("R7 restart while idle no read", fifo_level, 0);

    // R9 clear-to-send lost mid message
    for (int b = 0; b < 3; b++) push(8'(b*53 + 17), b == 2);
    pulse_start();
    repeat (5) @(negedge clk);
    cts = 1'b0;
    @(negedge clk);
    check("R9 close on cts loss", buf_close, 1);
    check("R9 cts flag", st_cts, 1);
    check("R9 halted", halted, 1);
    check("R9 line idle", txd, 1);
    check("R9 irq", irq, 1);
    check("R9 only first read", fifo_level, 2);
    cts = 1'b1;
    pulse_clr(3'b110);
    check("R10 cts flag cleared", {irq, st_cts}, 0);
    pulse_restart();
    pulse_start();
    wait_close(k);
    check("R9 remainder sent", k, 16);

    // R8 transparent escape pairs
    @(negedge clk);
    transp = 1'b1;
    push(ESC, 1'b0);
    pulse_start();
    repeat (6) @(negedge clk);
    check("R8 lone escape delays start", fifo_level, 1);
    check("R8 no error at start", {halted, st_un}, 0);
    push(8'h41, 1'b1);
    pulse_start();
    wait_close(k);
    check("R8 pair sent", k, 16);

    @(negedge clk);
    push(8'h22, 1'b0); push(ESC, 1'b0);
    pulse_start();
    wait_close(k);
    check("R8 escape underrun boundary", k, 8);
    check("R8 escape underrun flag", st_un, 1);
    check("R8 escape left in fifo", fifo_level, 1);
    @(negedge clk);
    pulse_clr(3'b101);
    pulse_restart();
    push(8'h33, 1'b1);
    pulse_start();
    wait_close(k);
    check("R8 pair after restart", k, 16);

    @(negedge clk);
    push(ESC, 1'b0); push(ESC, 1'b0); push(8'h55, 1'b1);
    pulse_start();
    wait_close(k);
    check("R8 doubled escape", k, 24);
    check("R8 doubled escape no flag", st_un, 0);

    @(negedge clk);
    push(ESC, 1'b1);
    pulse_start();
    wait_close(k);
    check("R8 escape tagged last", k, 8);
    check("R8 escape tagged last no flag", st_un, 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule